// File: doc/BRIEF.md
# Block-Copy DMA Engine with Selectable Bus Sharing

This engine copies a block of words from one region of a shared memory to another without processor involvement. Software loads a source pointer, a destination pointer and a word count through a four-entry register port. It then sets a start bit together with a bus-sharing mode. From then on the engine requests the shared bus from an external arbiter. Once granted, it moves each word as a read of the source followed by a write of the destination. When the last word has been written it raises an interrupt.

The sharing mode decides how the engine behaves toward the processor. In block mode the engine keeps its request up from the first word to the last, so the processor is locked out for the whole copy. In steal mode the engine drops its request for one cycle after every word, which lets the arbiter hand the bus back before the next word. In idle-only mode the engine asks for the bus only while the processor's request line is low, and it starts a word only after a cycle in which the processor did not want the bus.

The arbiter outside the block is expected to grant the bus one cycle after the engine requests it, and to take the grant away one cycle after the request drops. The memory returns read data one cycle after a read.

Top module: `xfer_dma`

## Requirements
- R1: After reset, all four registers read back as zero, `irq` is low and `dma_req` is low.
- R2: Register select 0 is the source pointer and select 1 is the destination pointer. Select 2 is the word count. Select 3 is control/status: bit 0 writes start and reads busy, bits 2:1 hold the mode (0 block, 1 steal, 2 idle-only, 3 behaves as block), and bit 3 reads the interrupt and clears it when written 1.
- R3: Each word is a one-cycle read at the source pointer, followed in the next cycle by a write of the returned data to the destination pointer. After the copy, the pointers read back advanced by the word count and the count reads zero.
- R4: `mem_re` and `mem_we` are only ever high in a cycle where `bus_gnt` is high, and never together.
- R5: In block mode the bus activity of one copy is a single unbroken run of 2×count cycles. The processor's request line has no effect on it.
- R6: In steal mode `dma_req` is low for exactly one cycle between consecutive words, and a read never directly follows a write.
- R7: In idle-only mode a read happens only in the cycle after one in which `cpu_req` was low. While `cpu_req` is held high, no word moves.
- R8: `irq` rises in the cycle right after the final write, and `dma_req` is already low in that cycle.
- R9: While busy, writes to the pointers, the count, the mode and the start bit are ignored.
- R10: `irq` stays high until a 1 is written to bit 3 of select 3. Writing 0 there leaves it set. If a clear arrives in the same cycle as the final write, the interrupt stays set.
- R11: A start with a count of zero raises `irq` in the next cycle, causes no bus activity and never shows busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Read data of the selected register |
| cpu_req | input | 1 | Processor's bus request, observed for idle-only mode |
| dma_req | output | 1 | Engine's bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant to the engine |
| mem_addr | output | AW | Memory word address, zero when not driving |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |
| irq | output | 1 | Completion interrupt |

## Verification
The interesting collision is the final write of a copy landing in the same cycle as a software write that clears the interrupt. The bench counts write strobes in block mode. On the cycle that carries the last one, it issues the clear at select 3, and it then expects `irq` to read high, because setting wins over clearing. A second overlap is a processor request arriving while the engine is between words in idle-only mode. For that case random `cpu_req` traffic is driven each cycle, and every read is checked against the request level of the cycle before it.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK    = 2'd0,
    MODE_STEAL    = 2'd1,
    MODE_IDLEONLY = 2'd2,
    MODE_ALTBLOCK = 2'd3
  } share_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam int CTL_START = 0;
  localparam int CTL_MODE_LO = 1;
  localparam int CTL_IRQ = 3;

endpackage

// File: rtl/xfer_dma_rstsync.sv
module xfer_dma_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic        busy,
  input  logic        step,
  input  logic        finish,
  output logic        go,
  output logic        last_word,
  output share_mode_e mode,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic        irq
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  share_mode_e   mode_q;
  logic          irq_q, irq_d;
  logic          src_en, dst_en, cnt_en, mode_en, irq_en;
  logic          ctl_wr, start_req, zero_done, cnt_zero;

  assign ctl_wr    = cfg_we && (cfg_sel == SEL_CTL);
  assign cnt_zero  = (cnt_q == '0);
  assign start_req = ctl_wr && cfg_wdata[CTL_START] && !busy;
  assign go        = start_req && !cnt_zero;
  assign zero_done = start_req && cnt_zero;

  always_comb begin
    src_en  = 1'b0;
    dst_en  = 1'b0;
    cnt_en  = 1'b0;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    if (cfg_we && !busy && (cfg_sel == SEL_SRC)) begin
      src_en = 1'b1;
      src_d  = cfg_wdata[AW-1:0];
    end else if (step) begin
      src_en = 1'b1;
      src_d  = src_q + AW'(1);
    end
    if (cfg_we && !busy && (cfg_sel == SEL_DST)) begin
      dst_en = 1'b1;
      dst_d  = cfg_wdata[AW-1:0];
    end else if (step) begin
      dst_en = 1'b1;
      dst_d  = dst_q + AW'(1);
    end
    if (cfg_we && !busy && (cfg_sel == SEL_CNT)) begin
      cnt_en = 1'b1;
      cnt_d  = cfg_wdata[CW-1:0];
    end else if (step) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_ONE;
    end
    mode_en = ctl_wr && !busy;
    irq_en  = finish || zero_done || (ctl_wr && cfg_wdata[CTL_IRQ]);
    irq_d   = finish || zero_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      mode_q <= MODE_BLOCK;
      irq_q  <= 1'b0;
    end else begin
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mode_en) mode_q <= share_mode_e'(cfg_wdata[CTL_MODE_LO +: 2]);
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  always_comb begin
    unique case (cfg_sel)
      SEL_SRC: cfg_rdata = DW'(src_q);
      SEL_DST: cfg_rdata = DW'(dst_q);
      SEL_CNT: cfg_rdata = DW'(cnt_q);
      default: cfg_rdata = DW'({irq_q, mode_q, busy});
    endcase
  end

  assign last_word = (cnt_q == CNT_ONE);
  assign mode      = mode_q;
  assign src       = src_q;
  assign dst       = dst_q;
  assign irq       = irq_q;
endmodule

// File: rtl/xfer_dma_seq.sv
module xfer_dma_seq
  import xfer_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  share_mode_e mode,
  input  logic        last_word,
  input  logic        cpu_req,
  input  logic        bus_gnt,
  output logic        busy,
  output logic        dma_req,
  output logic        rd_en,
  output logic        wr_en,
  output logic        finish
);
  seq_state_e state_q, state_d;
  logic       idle_only, may_ask;

  assign idle_only = (mode == MODE_IDLEONLY);
  assign may_ask   = !idle_only || !cpu_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_ARB;
      ST_ARB:  if (bus_gnt && may_ask) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        if (last_word)                state_d = ST_IDLE;
        else if (mode == MODE_STEAL)  state_d = ST_GAP;
        else if (idle_only)           state_d = ST_ARB;
        else                          state_d = ST_RD;
      end
      ST_GAP:  state_d = ST_ARB;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign rd_en   = (state_q == ST_RD);
  assign wr_en   = (state_q == ST_WR);
  assign finish  = wr_en && last_word;
  assign dma_req = rd_en || wr_en || ((state_q == ST_ARB) && may_ask);
endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          cpu_req,
  output logic          dma_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic          rst_int_n;
  logic          busy, step, finish, go, last_word, rd_en;
  share_mode_e   mode_q;
  logic [AW-1:0] src, dst;

  xfer_dma_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  xfer_dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .step(step), .finish(finish),
    .go(go), .last_word(last_word), .mode(mode_q),
    .src(src), .dst(dst), .irq(irq)
  );

  xfer_dma_seq u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .go(go), .mode(mode_q), .last_word(last_word),
    .cpu_req(cpu_req), .bus_gnt(bus_gnt),
    .busy(busy), .dma_req(dma_req), .rd_en(rd_en), .wr_en(step), .finish(finish)
  );

  assign mem_re    = rd_en;
  assign mem_we    = step;
  assign mem_addr  = rd_en ? src : (step ? dst : '0);
  assign mem_wdata = step ? mem_rdata : '0;
endmodule

// File: rtl/xfer_dma_chk.sv
module xfer_dma_chk
  import xfer_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [DW-1:0] cfg_wdata,
  input logic          cpu_req,
  input logic          dma_req,
  input logic          bus_gnt,
  input logic          mem_re,
  input logic          mem_we,
  input logic          irq,
  input logic          busy,
  input share_mode_e   mode_q
);
  logic irq_clear_wr;
  assign irq_clear_wr = cfg_we && (cfg_sel == SEL_CTL) && cfg_wdata[CTL_IRQ];

  AST_BUS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> bus_gnt); // R4
  AST_NO_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R4
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we); // R3
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_q == MODE_STEAL) |=> !mem_re); // R6
  AST_IDLEONLY_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mode_q == MODE_IDLEONLY) |-> !$past(cpu_req)); // R7
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dma_req); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear_wr) |=> irq); // R10
endmodule

bind xfer_dma xfer_dma_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .cpu_req(cpu_req), .dma_req(dma_req), .bus_gnt(bus_gnt),
  .mem_re(mem_re), .mem_we(mem_we), .irq(irq),
  .busy(busy), .mode_q(mode_q)
);

// File: tb/xfer_dma_test.sv
`timescale 1ns/1ps
module xfer_dma_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          cpu_req = 1'b0;
  logic          dma_req;
  logic          bus_gnt;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          irq;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit rnd_cpu = 0;
  bit done_flag = 0;

  int first_re, last_we, we_cnt, req_low, seen_re;
  int dummy;

  always #2.5 clk = ~clk;

  xfer_dma #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_req(cpu_req),
    .dma_req(dma_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      bus_gnt <= dma_req;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] ctl_word(input int mode, input bit start, input bit clr);
    return DW'({clr, mode[1:0], start});
  endfunction

  function automatic int span_expect(input int len);
    return 2 * len;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    if ((mem_re || mem_we) && !bus_gnt) chk(0, "R4 strobe without grant", 1, 0);
    if (mem_re && mem_we) chk(0, "R4 read and write together", 1, 0);
    if (mem_re && !seen_re) begin seen_re = 1; first_re = cyc; end
    if (mem_we) begin we_cnt++; last_we = cyc; end
    if (mode_trk == 2 && mem_re && cpu_req) chk(0, "R7 read after busy cpu cycle", 1, 0);
    if (seen_re && !dma_req && busy_trk && !mem_we) req_low++;
    if (rnd_cpu) cpu_req = $urandom_range(0, 1);
  endtask

  int  mode_trk = 0;
  bit  busy_trk = 0;

  task automatic cfg_write(input logic [1:0] sel, input logic [DW-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [DW-1:0] data);
    cfg_sel = sel;
    #0.5;
    data = cfg_rdata;
  endtask

  task automatic clear_stats();
    seen_re = 0; first_re = 0; last_we = 0; we_cnt = 0; req_low = 0;
  endtask

  task automatic wait_irq(output bit ok);
    int guard = 0;
    ok = 0;
    while (guard < 3000) begin
      tick();
      guard++;
      if (we_cnt > 0 && we_cnt == exp_len) busy_trk = 0;
      if (irq) begin ok = 1; break; end
    end
  endtask

  int exp_len = 0;

  task automatic run_copy(input int mode, input int src, input int dst, input int len,
                          input bit poke);
    logic [DW-1:0] snap [16];
    logic [DW-1:0] rd;
    bit ok;
    string tag;
    for (int i = 0; i < len; i++) snap[i] = mem[src + i];
    cfg_write(2'd0, DW'(src));
    cfg_write(2'd1, DW'(dst));
    cfg_write(2'd2, DW'(len));
    clear_stats();
    mode_trk = mode;
    exp_len = len;
    busy_trk = 1;
    cfg_write(2'd3, ctl_word(mode, 1, 0));
    if (poke) begin
      cfg_write(2'd0, DW'(8'hEE));
      cfg_write(2'd2, DW'(40));
      cfg_write(2'd3, ctl_word((mode + 1) % 3, 1, 0));
    end
    wait_irq(ok);
    busy_trk = 0;
    chk(ok, "R8 completion irq (watchdog)", ok, 1);
    if (!ok) return;
    chk(last_we == cyc - 1, "R8 irq one cycle after final write", cyc - last_we, 1);
    chk(!dma_req, "R8 request dropped at completion", dma_req, 0);
    chk(we_cnt == len, "R3 word writes", we_cnt, len);
    for (int i = 0; i < len; i++)
      if (mem[dst + i] !== snap[i]) chk(0, "R3 copied data", mem[dst + i], snap[i]);
    checks++;
    cfg_read(2'd0, rd); chk(rd == DW'(src + len), "R3/R9 src after copy", rd, src + len);
    cfg_read(2'd1, rd); chk(rd == DW'(dst + len), "R3 dst after copy", rd, dst + len);
    cfg_read(2'd2, rd); chk(rd == 0, "R3/R9 count after copy", rd, 0);
    cfg_read(2'd3, rd);
    chk(rd[0] == 0, "R2 busy low after copy", rd[0], 0);
    chk(rd[2:1] == mode[1:0], "R9 mode unchanged", rd[2:1], mode);
    chk(rd[3] == 1, "R2 irq readable", rd[3], 1);
    if (mode == 0 || mode == 3)
      chk(last_we - first_re + 1 == span_expect(len), "R5 unbroken block span",
          last_we - first_re + 1, span_expect(len));
    if (mode == 1)
      chk(req_low == len - 1, "R6 one released cycle per gap", req_low, len - 1);
    cfg_write(2'd3, ctl_word(mode, 0, 0));
    chk(irq == 1, "R10 writing zero keeps irq", irq, 1);
    cfg_write(2'd3, ctl_word(mode, 0, 1));
    chk(irq == 0, "R10 W1C clears irq", irq, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    bit ok;
    int guard;
    dummy = $urandom(32'h1D3A);
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      cfg_read(s[1:0], rd);
      chk(rd == 0, "R1 register reset value", rd, 0);
    end
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(dma_req == 0, "R1 request after reset", dma_req, 0);

    // R2 register readback
    cfg_write(2'd0, 32'h0000_1234);
    cfg_read(2'd0, rd); chk(rd == 32'h1234, "R2 src readback", rd, 32'h1234);
    cfg_write(2'd3, ctl_word(2, 0, 0));
    cfg_read(2'd3, rd); chk(rd == 32'h4, "R2 mode field bits 2:1", rd, 4);

    // R11 zero-length start
    cfg_write(2'd2, 0);
    clear_stats();
    cfg_write(2'd3, ctl_word(0, 1, 0));
    chk(irq == 1, "R11 zero count raises irq next cycle", irq, 1);
    cfg_read(2'd3, rd); chk(rd[0] == 0, "R11 never busy", rd[0], 0);
    repeat (3) tick();
    chk(seen_re == 0 && we_cnt == 0, "R11 no bus activity", we_cnt, 0);
    cfg_write(2'd3, ctl_word(0, 0, 1));
    chk(irq == 0, "R10 clear after zero copy", irq, 0);

    // directed per-mode copies with quiet processor
    run_copy(0, 3, 130, 5, 0);   // R5
    run_copy(1, 20, 150, 4, 0);  // R6
    run_copy(2, 40, 170, 6, 0);  // R7
    run_copy(3, 60, 190, 1, 0);  // R2 mode 3 as block

    // R9 writes during a busy copy are ignored
    run_copy(0, 70, 200, 9, 1);

    // random copies with random processor traffic
    rnd_cpu = 1;
    for (int n = 0; n < 12; n++) begin
      int m = $urandom_range(0, 3);
      int l = $urandom_range(1, 12);
      int s = $urandom_range(0, 127 - l);
      int d = 128 + $urandom_range(0, 127 - l);
      run_copy(m, s, d, l, 0);
    end
    rnd_cpu = 0;
    cpu_req = 0;

    // R5 block mode ignores a held processor request
    cpu_req = 1;
    run_copy(0, 90, 220, 4, 0);
    cpu_req = 0;

    // R7 idle-only mode stalls while processor holds the bus
    cpu_req = 1;
    cfg_write(2'd0, 100);
    cfg_write(2'd1, 240);
    cfg_write(2'd2, 3);
    clear_stats();
    mode_trk = 2;
    cfg_write(2'd3, ctl_word(2, 1, 0));
    repeat (20) tick();
    chk(seen_re == 0, "R7 no read while cpu requests", seen_re, 0);
    chk(dma_req == 0, "R7 request withheld", dma_req, 0);
    cfg_read(2'd2, rd); chk(rd == 3, "R7 count untouched while stalled", rd, 3);
    cpu_req = 0;
    exp_len = 3;
    busy_trk = 1;
    wait_irq(ok);
    busy_trk = 0;
    chk(ok && we_cnt == 3, "R7 copy completes after release", we_cnt, 3);
    for (int i = 0; i < 3; i++)
      chk(mem[240 + i] == mem[100 + i], "R7 stalled copy data", mem[240 + i], mem[100 + i]);
    cfg_write(2'd3, ctl_word(2, 0, 1));

    // R10 clear colliding with the final write: set wins
    cfg_write(2'd0, 10);
    cfg_write(2'd1, 140);
    cfg_write(2'd2, 4);
    clear_stats();
    mode_trk = 0;
    cfg_write(2'd3, ctl_word(0, 1, 0));
    guard = 0;
    while (guard < 100) begin
      tick();
      guard++;
      if (mem_we && we_cnt == 4) break;
    end
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = ctl_word(0, 0, 1);
    tick();
    cfg_we = 1'b0;
    chk(irq == 1, "R10 set beats clear in same cycle", irq, 1);
    cfg_write(2'd3, ctl_word(0, 0, 1));
    chk(irq == 0, "R10 later clear works", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule